// File: doc/BRIEF.md
# Interleaved Burst Address Generator

This block produces the word address presented to a synchronous burst cache RAM on each clock. An external address is captured as the base of a new burst whenever either of two active-low address strobes is seen low at a rising clock edge. One strobe comes from the processor side and the other from the cache controller side. Capturing a new base cancels any burst already running.

During a burst, only the low two address bits change. They follow the interleaved cache-line order: the starting offset XOR a beat counter that runs 0, 1, 2, 3 and then wraps. An active-low advance input allows each step. While it is high the address is held, which inserts a wait state. The chip enable is looked at only on load cycles and decides whether the burst that follows is selected. A synchronous active-high reset deselects the block and clears its address state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `addrValid` = 0 and `burstAddr` = 0.
- R2: When `procStrobeN` or `ctrlStrobeN` is 0 at a rising edge, `burstAddr` equals the `extAddr` of that edge from the following cycle. `advanceN` has no effect on that edge.
- R3: Either strobe alone, or both together, perform the same load. A load in the middle of a burst discards the old burst and restarts at the new offset.
- R4: On an edge with both strobes at 1, `advanceN` = 0 and the block selected, the beat count steps by one. The low two bits then read (start offset XOR count), so a start of 01 gives 01, 00, 11, 10.
- R5: Bits 15:2 of `burstAddr` hold the loaded value for the whole burst.
- R6: An edge with both strobes at 1 and `advanceN` = 1 leaves `burstAddr` unchanged.
- R7: After four steps the address returns to the burst's starting address.
- R8: `chipEnN` is sampled only on load edges. On such an edge, 0 sets `addrValid` to 1 and 1 sets it to 0. On any other edge `chipEnN` has no effect.
- R9: While `addrValid` is 0, `advanceN` is ignored and `burstAddr` holds until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| extAddr | input | 16 | External word address captured on a load |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipEnN | input | 1 | Chip enable, active low, sampled on loads |
| burstAddr | output | 16 | Internal address for the current cycle |
| addrValid | output | 1 | High while the current burst is selected |

## Verification
The main stepping function is tried from two different start offsets (01 and 10). These show a true XOR interleave apart from plain incrementing, and each burst is carried through a full wrap. Held cycles are placed in the middle of a burst to separate a hold from a step. Loads come from each strobe alone and from both together, at the start of a burst and in the middle of one. Deselected loads followed by advance pulses show that the enable is sampled only on loads and that stepping is frozen while deselected.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // capture external address, restart beat count
    logic step;  // advance beat count by one
  } burstCmd_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      advanceN,
  input  logic      chipEnN,
  output burstCmd_t cmd,
  output logic      selected
);
  logic anyStrobe;

  always_comb begin
    anyStrobe = !procStrobeN || !ctrlStrobeN;
    cmd.load  = anyStrobe;
    cmd.step  = !anyStrobe && selected && !advanceN;
  end

  always_ff @(posedge clk) begin
    if (rst)
      selected <= 1'b0;
    else if (anyStrobe)
      selected <= !chipEnN;
  end

  AST_CE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    anyStrobe |=> (selected == !$past(chipEnN))); // R8
  AST_CE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !anyStrobe |=> $stable(selected)); // R8
  AST_NO_STEP_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!anyStrobe && !selected) |=> !selected); // R9
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burstCmd_t         cmd,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int HI_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [OFFS_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (cmd.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (cmd.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  // interleaved order: each offset bit toggled by the matching count bit
  for (genvar b = 0; b < OFFS_W; b++) begin : gOffs
    assign burstAddr[b] = baseAddr[b] ^ beatCnt[b];
  end
  assign burstAddr[ADDR_W-1:OFFS_W] = baseAddr[ADDR_W-1:OFFS_W];

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    cmd.load |=> (burstAddr == $past(extAddr))); // R2
  AST_HIGH_FIXED: assert property (@(posedge clk) disable iff (rst)
    !cmd.load |=> $stable(burstAddr[ADDR_W-1:OFFS_W])); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmd.load && !cmd.step) |=> $stable(burstAddr)); // R6
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    cmd.step |=> (burstAddr[OFFS_W-1:0] != $past(burstAddr[OFFS_W-1:0]))); // R4
  if (HI_W < 1) begin : gBadWidth
    initial $error("address narrower than offset");
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              chipEnN,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              addrValid
);
  burstCmd_t cmd;

  burst_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipEnN(chipEnN),
    .cmd(cmd), .selected(addrValid)
  );

  burst_datapath #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) uPath (
    .clk(clk), .rst(rst), .cmd(cmd),
    .extAddr(extAddr), .burstAddr(burstAddr)
  );
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] extAddr = '0;
  logic        procStrobeN = 1'b1;
  logic        ctrlStrobeN = 1'b1;
  logic        advanceN = 1'b1;
  logic        chipEnN = 1'b1;
  logic [15:0] burstAddr;
  logic        addrValid;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen dut (
    .clk(clk), .rst(rst), .extAddr(extAddr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .chipEnN(chipEnN),
    .burstAddr(burstAddr), .addrValid(addrValid)
  );

  // {pN, cN, advN, ceN, addr[15:0], expValid, expAddr[15:0], req[3:0]}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {4'b0110, 16'h1235, 1'b1, 16'h1235, 4'd2}, // R2 processor load, offset 01
    {4'b1100, 16'h0000, 1'b1, 16'h1234, 4'd4}, // R4 01^1
    {4'b1100, 16'h0000, 1'b1, 16'h1237, 4'd4}, // R4 01^2
    {4'b1110, 16'h0000, 1'b1, 16'h1237, 4'd6}, // R6 hold
    {4'b1100, 16'hFFFF, 1'b1, 16'h1236, 4'd5}, // R5 high bits fixed, 01^3
    {4'b1100, 16'h0000, 1'b1, 16'h1235, 4'd7}, // R7 wrap to start
    {4'b1000, 16'hABCE, 1'b1, 16'hABCE, 4'd3}, // R3 controller load, adv ignored
    {4'b1100, 16'h0000, 1'b1, 16'hABCF, 4'd4}, // R4 10^1
    {4'b1100, 16'h0000, 1'b1, 16'hABCC, 4'd4}, // R4 10^2
    {4'b0110, 16'h0F03, 1'b1, 16'h0F03, 4'd3}, // R3 interrupt mid-burst
    {4'b1101, 16'h0000, 1'b1, 16'h0F02, 4'd8}, // R8 ce ignored off-load
    {4'b0111, 16'h5550, 1'b0, 16'h5550, 4'd8}, // R8 deselecting load
    {4'b1100, 16'h0000, 1'b0, 16'h5550, 4'd9}, // R9 adv ignored
    {4'b1100, 16'h0000, 1'b0, 16'h5550, 4'd9}, // R9 adv ignored
    {4'b1010, 16'h8002, 1'b1, 16'h8002, 4'd2}, // R2 reselect via controller
    {4'b0010, 16'h4441, 1'b1, 16'h4441, 4'd3}, // R3 both strobes
    {4'b1100, 16'h0000, 1'b1, 16'h4440, 4'd4}  // R4
  };

  task automatic check(input string req, input logic v, input logic [15:0] a);
    total++;
    if (addrValid !== v || burstAddr !== a) begin
      bad++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, addrValid, burstAddr, v, a);
    end
  endtask

  task automatic applyEdge(input logic pN, input logic cN, input logic aN,
                           input logic ceN, input logic [15:0] ad);
    @(negedge clk);
    procStrobeN = pN; ctrlStrobeN = cN; advanceN = aN; chipEnN = ceN; extAddr = ad;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b0, 16'h0000); // reset state
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      applyEdge(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36:21]);
      check($sformatf("R%0d", VEC[i][3:0]), VEC[i][20], VEC[i][19:4]);
    end
    // R7: full wrap from offset 10 with waits in between
    applyEdge(1'b0, 1'b1, 1'b1, 1'b0, 16'h2222);
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    applyEdge(1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R4", 1'b1, 16'h2221); // 10^3
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R7", 1'b1, 16'h2222);
    // R1: reset during an active burst
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", 1'b0, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    applyEdge(1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    check("R9", 1'b0, 16'h0000); // after reset, advance does nothing
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule